// File: doc/BRIEF.md
# Nonlinear Shift-Register Noise Generator

This block produces a pseudo-random bit stream for percussive sound effects such as drums, shots and explosions. A 32-stage shift register advances on a selectable step source and inserts, at each step, a bit formed by a nonlinear function of a few of its own stages. The step source is either an external clock-enable input or an internal divider that emits one enable pulse every `DIV` clock cycles.

The raw stage-32 bit drives a digital stand-in for an integrating low-pass filter. This is a saturating up/down accumulator that moves by a programmable step on every clock cycle. A comparator with hysteresis then squares the slewed value back into a clean noise bit. Small steps keep the accumulator from following quick raw toggles, so the filtered bit carries mostly low-frequency content.

Top module: `noise_gen_top`

## Requirements
- R1: While `srst` is high at a clock edge, the register loads the seed `SEED` (stage N is bit N-1), the accumulator becomes 0, the divider count becomes 0 and `noise_bit` becomes 0. With the default seed 1, `raw_bit` reads 0 after reset.
- R2: On each clock edge with the step enable active, the contents of stage N move to stage N+1 and a new bit enters stage 1. `raw_bit` always shows stage 32.
- R3: The bit entering stage 1 is the inverse of ((stage2 XOR stage30) OR (stage2 AND stage26 AND stage27 AND stage28 AND stage29 AND stage30)).
- R4: With `clk_sel` = 0 the register steps exactly on the edges where `ext_step_en` is 1. With `clk_sel` = 1, `ext_step_en` has no effect.
- R5: With `clk_sel` = 1 the register steps once every `DIV` clock cycles. The divider counts 0 to `DIV`-1 on every cycle after reset and enables a step on the edge where its count is `DIV`-1.
- R6: On every clock edge the accumulator adds `step_size` if the current `raw_bit` is 1 and subtracts it if `raw_bit` is 0. A step of 0 leaves it unchanged.
- R7: The accumulator saturates at 0 and at 2^`ACC_W`-1 and never wraps.
- R8: On each edge `noise_bit` becomes 1 if the accumulator is above `HI_TH`, becomes 0 if it is below `LO_TH`, and otherwise holds. It therefore lags the accumulator by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| srst | input | 1 | Synchronous reset, active high |
| clk_sel | input | 1 | Step source: 0 selects the external enable, 1 selects the internal divider |
| ext_step_en | input | 1 | External step enable |
| step_size | input | STEP_W | Accumulator slew per clock |
| raw_bit | output | 1 | Stage 32 of the shift register |
| noise_bit | output | 1 | Filtered, hysteresis-squared noise |

## Verification
The external source is driven with a sparse random enable, which separates correct step gating from free running. The internal source is run while `ext_step_en` toggles randomly, which shows both the divider cadence and that the external input is ignored in that mode. Random step sizes are mixed with held runs of zero and of the maximum step. A zero step separates a held accumulator from a drifting one, and the maximum step forces saturation and repeated threshold crossings that show whether the hysteresis holds. A reset in mid-run confirms that the seed is reloaded from any state.

// File: rtl/noise_pkg.sv
package noise_pkg;
  localparam int SR_STAGES = 32;
  typedef logic [SR_STAGES-1:0] sr_word_t;
  typedef enum logic {SRC_EXT = 1'b0, SRC_INT = 1'b1} src_sel_e;

  // Stage N of the register is bit N-1 of the word.
  function automatic logic feedback_bit(sr_word_t s);
    logic lin_term;
    logic and_term;
    lin_term = s[1] ^ s[29];
    and_term = s[1] & (&s[29:25]);
    return ~(lin_term | and_term);
  endfunction
endpackage

// File: rtl/noise_tick_gen.sv
module noise_tick_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic srst,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      localparam logic [CW-1:0] LAST = CW'(DIV - 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (srst) cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == LAST);
    end
  endgenerate
endmodule

// File: rtl/noise_shift_reg.sv
module noise_shift_reg
  import noise_pkg::*;
#(
  parameter sr_word_t SEED = 32'h0000_0001
) (
  input  logic     clk,
  input  logic     srst,
  input  logic     shift_en,
  output sr_word_t state,
  output logic     fb_bit
);
  assign fb_bit = feedback_bit(state);

  always_ff @(posedge clk) begin
    if (srst) state <= SEED;
    else if (shift_en) state <= {state[SR_STAGES-2:0], fb_bit};
  end
endmodule

// File: rtl/noise_slew_filter.sv
module noise_slew_filter #(
  parameter int ACC_W  = 8,
  parameter int STEP_W = 4,
  parameter int HI_TH  = 191,
  parameter int LO_TH  = 64
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              dir_up,
  input  logic [STEP_W-1:0] step_size,
  output logic [ACC_W-1:0]  acc,
  output logic              noise_bit
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;
  localparam logic [ACC_W-1:0] HI_V = ACC_W'(HI_TH);
  localparam logic [ACC_W-1:0] LO_V = ACC_W'(LO_TH);

  function automatic logic [ACC_W-1:0] slew(logic [ACC_W-1:0] cur,
                                            logic [STEP_W-1:0] st,
                                            logic up);
    logic [ACC_W:0] wide;
    logic [ACC_W:0] stw;
    stw = (ACC_W + 1)'(st);
    if (up) begin
      wide = {1'b0, cur} + stw;
      return (wide > {1'b0, ACC_MAX}) ? ACC_MAX : wide[ACC_W-1:0];
    end
    return (stw > {1'b0, cur}) ? '0 : cur - stw[ACC_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (srst) begin
      acc       <= '0;
      noise_bit <= 1'b0;
    end else begin
      acc <= slew(acc, step_size, dir_up);
      if (acc > HI_V) noise_bit <= 1'b1;
      else if (acc < LO_V) noise_bit <= 1'b0;
    end
  end
endmodule

// File: rtl/noise_gen_top.sv
module noise_gen_top
  import noise_pkg::*;
#(
  parameter sr_word_t SEED   = 32'h0000_0001,
  parameter int       DIV    = 8,
  parameter int       ACC_W  = 8,
  parameter int       STEP_W = 4,
  parameter int       HI_TH  = 191,
  parameter int       LO_TH  = 64
) (
  input  logic              clk,
  input  logic              srst,
  input  logic              clk_sel,
  input  logic              ext_step_en,
  input  logic [STEP_W-1:0] step_size,
  output logic              raw_bit,
  output logic              noise_bit
);
  logic             tick;
  logic             shift_en;
  logic             fb_bit;
  sr_word_t         sr_state;
  logic [ACC_W-1:0] acc_val;
  src_sel_e         src;

  assign src      = src_sel_e'(clk_sel);
  assign shift_en = (src == SRC_INT) ? tick : ext_step_en;

  noise_tick_gen #(.DIV(DIV)) u_tick (
    .clk(clk), .srst(srst), .tick(tick)
  );

  noise_shift_reg #(.SEED(SEED)) u_sr (
    .clk(clk), .srst(srst), .shift_en(shift_en),
    .state(sr_state), .fb_bit(fb_bit)
  );

  assign raw_bit = sr_state[SR_STAGES-1];

  noise_slew_filter #(
    .ACC_W(ACC_W), .STEP_W(STEP_W), .HI_TH(HI_TH), .LO_TH(LO_TH)
  ) u_filt (
    .clk(clk), .srst(srst), .dir_up(raw_bit), .step_size(step_size),
    .acc(acc_val), .noise_bit(noise_bit)
  );
endmodule

// File: rtl/noise_gen_checker.sv
module noise_gen_checker #(
  parameter int DIV   = 8,
  parameter int ACC_W = 8,
  parameter int HI_TH = 191,
  parameter int LO_TH = 64
) (
  input logic             clk,
  input logic             srst,
  input logic             clk_sel,
  input logic             ext_step_en,
  input logic             tick,
  input logic             shift_en,
  input logic [31:0]      state,
  input logic [ACC_W-1:0] acc,
  input logic             raw_bit,
  input logic             noise_bit
);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;
  localparam logic [ACC_W-1:0] HI_V = ACC_W'(HI_TH);
  localparam logic [ACC_W-1:0] LO_V = ACC_W'(LO_TH);

  assert_hold_R4: assert property (@(posedge clk) disable iff (srst)
    (!clk_sel && !ext_step_en) |=> $stable(state));

  assert_shift_R2: assert property (@(posedge clk) disable iff (srst)
    shift_en |=> (state[31:1] == $past(state[30:0])));

  assert_feedback_R3: assert property (@(posedge clk) disable iff (srst)
    shift_en |=> (state[0] == !(($past(state[1]) != $past(state[29])) ||
                  ($past(state[1]) && ($past(state[29:25]) == 5'b11111)))));

  assert_raw_stage_R2: assert property (@(posedge clk) disable iff (srst)
    raw_bit == state[31]);

  generate
    if (DIV > 1) begin : g_tick_chk
      assert_tick_gap_R5: assert property (@(posedge clk) disable iff (srst)
        tick |=> !tick);
    end
  endgenerate

  assert_sat_top_R7: assert property (@(posedge clk) disable iff (srst)
    (raw_bit && acc == ACC_MAX) |=> (acc == ACC_MAX));

  assert_sat_bot_R7: assert property (@(posedge clk) disable iff (srst)
    (!raw_bit && acc == '0) |=> (acc == '0));

  assert_rise_R8: assert property (@(posedge clk) disable iff (srst)
    (acc > HI_V) |=> noise_bit);

  assert_fall_R8: assert property (@(posedge clk) disable iff (srst)
    (acc < LO_V) |=> !noise_bit);

  assert_band_hold_R8: assert property (@(posedge clk) disable iff (srst)
    (acc >= LO_V && acc <= HI_V) |=> $stable(noise_bit));
endmodule

bind noise_gen_top noise_gen_checker #(
  .DIV(DIV), .ACC_W(ACC_W), .HI_TH(HI_TH), .LO_TH(LO_TH)
) u_chk (
  .clk(clk), .srst(srst), .clk_sel(clk_sel), .ext_step_en(ext_step_en),
  .tick(tick), .shift_en(shift_en), .state(sr_state), .acc(acc_val),
  .raw_bit(raw_bit), .noise_bit(noise_bit)
);

// File: tb/noise_gen_top_test.sv
`timescale 1ns/1ps
module noise_gen_top_test;
  localparam logic [31:0] SEED = 32'h0000_0001;
  localparam int DIV = 8, ACC_W = 8, STEP_W = 4, HI_TH = 191, LO_TH = 64;
  localparam int ACC_TOP = (1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic clk_sel = 1'b0;
  logic ext_step_en = 1'b0;
  logic [STEP_W-1:0] step_size = '0;
  logic raw_bit, noise_bit;

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  noise_gen_top #(.SEED(SEED), .DIV(DIV), .ACC_W(ACC_W), .STEP_W(STEP_W),
                  .HI_TH(HI_TH), .LO_TH(LO_TH)) uut (
    .clk(clk), .srst(srst), .clk_sel(clk_sel), .ext_step_en(ext_step_en),
    .step_size(step_size), .raw_bit(raw_bit), .noise_bit(noise_bit));

  // Bench model, built from the requirements.
  logic [31:0] m_sr;
  int m_acc, m_cnt;
  logic m_noise;

  function automatic logic stage(logic [31:0] s, int n);
    return s[n-1];
  endfunction

  function automatic logic model_fb(logic [31:0] s);
    logic x, a;
    x = stage(s, 2) ^ stage(s, 30);
    a = stage(s, 2);
    for (int k = 26; k <= 30; k++) a = a & stage(s, k);
    return !(x || a);
  endfunction

  function automatic int model_slew(int cur, int st, logic up);
    int v;
    v = up ? cur + st : cur - st;
    if (v < 0) v = 0;
    if (v > ACC_TOP) v = ACC_TOP;
    return v;
  endfunction

  always @(posedge clk) begin
    if (srst) begin
      m_sr <= SEED; m_acc <= 0; m_cnt <= 0; m_noise <= 1'b0;
    end else begin
      logic go;
      go = clk_sel ? (m_cnt == DIV - 1) : ext_step_en;
      m_cnt <= (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
      if (go) m_sr <= {m_sr[30:0], model_fb(m_sr)};
      m_acc <= model_slew(m_acc, int'(step_size), m_sr[31]);
      if (m_acc > HI_TH) m_noise <= 1'b1;
      else if (m_acc < LO_TH) m_noise <= 1'b0;
    end
  end

  task automatic check(logic act, logic exp, string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0b expected %0b", req, $time, act, exp);
    end
  endtask

  task automatic compare_all(string tag);
    check(raw_bit, m_sr[31], {tag, " raw R2 R3"});
    check(noise_bit, m_noise, {tag, " noise R6 R7 R8"});
  endtask

  task automatic run(int cycles, int mode, int ext_pct, int step_mode);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all(mode == 0 ? "R4 ext" : "R5 int");
      clk_sel = (mode != 0);
      ext_step_en = (($urandom % 100) < ext_pct);
      case (step_mode)
        0: step_size = STEP_W'($urandom);
        1: step_size = '0;
        default: step_size = '1;
      endcase
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    srst = 1'b0;
    @(negedge clk);
    // R1: reset state, one cycle after release nothing has moved yet only for noise
    check(noise_bit, 1'b0, "R1 reset noise");
    check(raw_bit, SEED[31], "R1 reset raw");
    // R4: external source, sparse enable, random step
    run(3000, 0, 30, 0);
    // R6: zero step holds the accumulator, noise must hold
    run(200, 0, 50, 1);
    // R7: maximum step forces saturation
    run(600, 0, 5, 2);
    // R5: internal source with ext toggling (ignored)
    run(3000, 1, 50, 0);
    run(400, 1, 50, 2);
    // R1: reset in mid-run reloads seed
    @(negedge clk);
    srst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(raw_bit, SEED[31], "R1 mid reset raw");
    check(noise_bit, 1'b0, "R1 mid reset noise");
    srst = 1'b0;
    run(2000, 1, 50, 0);
    run(1500, 0, 70, 0);
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule